// File: doc/BRIEF.md
# Dual Return-Address Buffer for Delay-Slot Restart

This block sits beside the fetch unit of a pipelined processor with a single branch delay slot. When an interrupt or trap is taken it records two restart addresses: the address of the first instruction that did not complete, and the address that must follow it. Usually the second is just the next word. When the exception arrives after a taken branch but before its delay-slot instruction, the second address is the branch target. The processor can then resume correctly without executing the branch again.

On an interrupt-return request the block hands both addresses to fetch, one after the other, over a valid/ready handshake. The first-resume address goes first. The follow-on address goes only after fetch has accepted the first one, and it is flagged as the last of the pair. Between capture and the end of the replay the buffers are held. A second exception cannot overwrite them unless the nesting enable is high.

Top module: `retpc_buffer`

## Requirements
- R1: After reset both saved addresses are zero, `held` is 0 and `rpl_valid` is 0.
- R2: An accepted exception with `in_delay` = 0 saves `cur_pc` as the first-resume address and `cur_pc` + 4 as the follow-on address.
- R3: An accepted exception with `in_delay` = 1 saves `cur_pc` (the delay-slot address) as the first-resume address and `br_target` as the follow-on address.
- R4: An accepted exception raises `held` on the next cycle. While `held` is 1 and `nest_en` is 0, `exc_take` leaves both saved addresses unchanged.
- R5: While `held` is 1 and the replay is idle, `exc_take` with `nest_en` = 1 replaces both saved addresses according to R2/R3.
- R6: When `held` is 1 and no replay is running, a `ret_req` pulse makes `rpl_valid` high on the next cycle. `rpl_pc` then shows the first-resume address with `rpl_last` = 0. After that transfer is accepted, the next cycle shows the follow-on address with `rpl_last` = 1.
- R7: While `rpl_valid` is 1 and `rpl_ready` is 0, `rpl_valid`, `rpl_pc` and `rpl_last` stay unchanged on the next cycle.
- R8: `ret_req` while `held` is 0 has no effect: `rpl_valid` stays 0.
- R9: Acceptance of the follow-on transfer ends the replay. On the next cycle `rpl_valid` and `held` are both 0.
- R10: `exc_take` while a replay is running is ignored, whatever `nest_en` is, and the replay completes with the addresses saved before it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| exc_take | input | 1 | Exception or interrupt is being taken this cycle |
| nest_en | input | 1 | Allow a capture while addresses are held |
| cur_pc | input | AW | Address of the first instruction not completed |
| in_delay | input | 1 | `cur_pc` is the delay slot of a taken branch |
| br_target | input | AW | Target of that taken branch |
| ret_req | input | 1 | Interrupt-return request |
| rpl_valid | output | 1 | Replay address is offered to fetch |
| rpl_ready | input | 1 | Fetch accepts the offered address |
| rpl_pc | output | AW | Offered restart address |
| rpl_last | output | 1 | Offered address is the follow-on (second) one |
| held | output | 1 | Saved addresses are frozen for the handler |

## Verification
The embedded assertions check the handshake rules on every cycle. An offer stays put until fetch accepts it, the first transfer is always followed directly by the flagged second one, and no offer is made without held addresses. They also check that held addresses do not move unless nesting is enabled, and that a sequential capture yields a follow-on exactly one word beyond the first. Only the bench scenarios can show that the right values were saved and then delivered through the replay. These cover the branch-target case, the ignored and the permitted nested captures, a return request with nothing held, an exception during a replay, and back-pressure of several cycles.

// File: rtl/retpc_buffer.sv
module retpc_buffer #(
  parameter int AW = 32,
  parameter int WORD_BYTES = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          exc_take,
  input  logic          nest_en,
  input  logic [AW-1:0] cur_pc,
  input  logic          in_delay,
  input  logic [AW-1:0] br_target,
  input  logic          ret_req,
  output logic          rpl_valid,
  input  logic          rpl_ready,
  output logic [AW-1:0] rpl_pc,
  output logic          rpl_last,
  output logic          held
);

  localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

  typedef enum logic [1:0] {IDLE, SEND1, SEND0} rpl_state_t;

  rpl_state_t   state_q;
  logic [AW-1:0] pc0_q, pc1_q;
  logic          held_q;

  wire idle    = (state_q == IDLE);
  wire capture = exc_take && idle && (!held_q || nest_en);
  wire start   = ret_req && idle && held_q && !capture;
  wire xfer    = rpl_valid && rpl_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc0_q   <= '0;
      pc1_q   <= '0;
      held_q  <= 1'b0;
      state_q <= IDLE;
    end else begin
      if (capture) begin
        pc1_q  <= cur_pc;
        pc0_q  <= in_delay ? br_target : cur_pc + STEP;
        held_q <= 1'b1;
      end
      case (state_q)
        IDLE:  if (start) state_q <= SEND1;
        SEND1: if (xfer)  state_q <= SEND0;
        SEND0: if (xfer) begin
          state_q <= IDLE;
          held_q  <= 1'b0;
        end
        default: state_q <= IDLE;
      endcase
    end
  end

  assign rpl_valid = (state_q != IDLE);
  assign rpl_last  = (state_q == SEND0);
  assign rpl_pc    = rpl_last ? pc0_q : pc1_q;
  assign held      = held_q;

  assert_offer_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid && !rpl_ready |=> rpl_valid && $stable(rpl_pc) && $stable(rpl_last));

  assert_second_follows_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid && rpl_ready && !rpl_last |=> rpl_valid && rpl_last);

  assert_replay_ends_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid && rpl_ready && rpl_last |=> !rpl_valid && !held);

  assert_offer_needs_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid |-> held);

  assert_frozen_bufs_R4: assert property (@(posedge clk) disable iff (!rst_n)
    held && !nest_en |=> $stable(pc0_q) && $stable(pc1_q));

  assert_replay_no_capture_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rpl_valid |=> $stable(pc0_q) && $stable(pc1_q));

  assert_seq_pair_R2: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && !in_delay && !held && !rpl_valid |=> pc0_q == pc1_q + STEP);

  assert_held_rises_R4: assert property (@(posedge clk) disable iff (!rst_n)
    exc_take && !rpl_valid |=> held);

endmodule

// File: tb/test_retpc_buffer.sv
module test_retpc_buffer;
  localparam int  AW = 32;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          exc_take = 1'b0, nest_en = 1'b0, in_delay = 1'b0;
  logic [AW-1:0] cur_pc = '0, br_target = '0;
  logic          ret_req = 1'b0, rpl_ready = 1'b0;
  logic          rpl_valid, rpl_last, held;
  logic [AW-1:0] rpl_pc;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  retpc_buffer #(.AW(AW)) i_retpc_buffer (
    .clk(clk), .rst_n(rst_n), .exc_take(exc_take), .nest_en(nest_en),
    .cur_pc(cur_pc), .in_delay(in_delay), .br_target(br_target),
    .ret_req(ret_req), .rpl_valid(rpl_valid), .rpl_ready(rpl_ready),
    .rpl_pc(rpl_pc), .rpl_last(rpl_last), .held(held)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(string req, logic [AW-1:0] act, logic [AW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic take_exc(logic [AW-1:0] pc, logic dly, logic [AW-1:0] tgt, logic nest);
    exc_take = 1'b1; cur_pc = pc; in_delay = dly; br_target = tgt; nest_en = nest;
    step();
    exc_take = 1'b0; in_delay = 1'b0; nest_en = 1'b0;
  endtask

  task automatic replay(string req, logic [AW-1:0] e1, logic [AW-1:0] e0, int stall);
    ret_req = 1'b1;
    step();
    ret_req = 1'b0;
    check({req, " first valid"}, AW'(rpl_valid), 1);
    check({req, " first pc"}, rpl_pc, e1);
    check({req, " first last"}, AW'(rpl_last), 0);
    for (int i = 0; i < stall; i++) begin
      step();
      check("R7 hold valid", AW'(rpl_valid), 1);
      check("R7 hold pc", rpl_pc, e1);
    end
    rpl_ready = 1'b1;
    step();
    check({req, " second pc"}, rpl_pc, e0);
    check({req, " second last"}, AW'(rpl_last), 1);
    step();
    rpl_ready = 1'b0;
    check("R9 valid drops", AW'(rpl_valid), 0);
    check("R9 held drops", AW'(held), 0);
  endtask

  task automatic t_reset();
    check("R1 valid", AW'(rpl_valid), 0);
    check("R1 held", AW'(held), 0);
    check("R1 pc", rpl_pc, 0);
  endtask

  task automatic t_sequential();
    take_exc(32'h0000_1000, 1'b0, 32'hDEAD_0000, 1'b0);
    check("R4 held set", AW'(held), 1);
    replay("R2 R6", 32'h0000_1000, 32'h0000_1004, 0);
  endtask

  task automatic t_delay_slot();
    take_exc(32'h0000_2008, 1'b1, 32'h0000_8000, 1'b0);
    replay("R3", 32'h0000_2008, 32'h0000_8000, 3);
  endtask

  task automatic t_frozen();
    take_exc(32'h0000_3000, 1'b1, 32'h0000_9000, 1'b0);
    take_exc(32'h0000_5550, 1'b0, 32'h0, 1'b0);
    replay("R4 frozen", 32'h0000_3000, 32'h0000_9000, 1);
  endtask

  task automatic t_nested();
    take_exc(32'h0000_4000, 1'b0, 32'h0, 1'b0);
    take_exc(32'h0000_6100, 1'b1, 32'h0000_7700, 1'b1);
    replay("R5", 32'h0000_6100, 32'h0000_7700, 0);
  endtask

  task automatic t_no_hold_return();
    ret_req = 1'b1;
    step();
    ret_req = 1'b0;
    check("R8 no offer", AW'(rpl_valid), 0);
    step();
    check("R8 no offer later", AW'(rpl_valid), 0);
  endtask

  task automatic t_exc_during_replay();
    take_exc(32'h0000_A000, 1'b0, 32'h0, 1'b0);
    ret_req = 1'b1;
    step();
    ret_req = 1'b0;
    take_exc(32'h0000_BBB0, 1'b1, 32'h0000_CCC0, 1'b1);
    check("R10 first pc", rpl_pc, 32'h0000_A000);
    rpl_ready = 1'b1;
    step();
    check("R10 second pc", rpl_pc, 32'h0000_A004);
    check("R10 second last", AW'(rpl_last), 1);
    step();
    rpl_ready = 1'b0;
    check("R10 end held", AW'(held), 0);
  endtask

  initial begin
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset();
    t_no_hold_return();
    t_sequential();
    t_delay_slot();
    t_frozen();
    t_nested();
    t_exc_during_replay();
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule